// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every data beat of an SDRAM burst. One clock after a start request it presents the first column, then one new column per clock, and it flags the final beat. The order of the columns follows the burst type, either linear or interleaved. The burst length is four beats, eight beats or a whole 256-column page. A page burst runs until a stop request ends it. A separate mode keeps the programmed length for reads but limits each write to one beat.

A memory controller drives the block once a row is open. The controller pulses `go_i` with the first column, the length code, the ordering, the direction and the single-write mode. It then reads `col_o`, `beat_vld_o` and `beat_last_o` every cycle to steer the column commands. Bank and row selection and the data path lie outside this block.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and after it is released, with no start request, `beat_vld_o`, `beat_last_o` and `cfg_err_o` are 0.
- R2: One clock after `go_i` is sampled high, `beat_vld_o` is 1 and `col_o` equals the sampled `start_col_i`.
- R3: With linear ordering (`ilv_i`=0) and length 4 or 8, beat k carries the start column with its low 2 or 3 bits replaced by (start + k) modulo 4 or 8. The upper bits stay unchanged.
- R4: With interleaved ordering (`ilv_i`=1) and length 4 or 8, beat k carries the start column with its low 2 or 3 bits XORed with k. The upper bits stay unchanged.
- R5: Length code `len_i` selects the burst length: 2'b00 gives 4 beats, 2'b01 gives 8 beats, and 2'b10 or 2'b11 gives a full page. For length 4 or 8, `beat_last_o` is high on the final beat only, and `beat_vld_o` is low on the clock after that beat.
- R6: A full-page burst steps the column by +1 modulo 256 on each beat. It continues past 256 beats and never raises `beat_last_o`.
- R7: If `stop_i` is sampled high on a valid beat, and no new start is sampled in the same cycle, `beat_vld_o` is low on the next clock.
- R8: If both `wr_i` and `wr_single_i` are 1 at the start, the burst has exactly one beat, and `beat_last_o` is high on that beat. Reads, and writes with `wr_single_i`=0, use the programmed length.
- R9: Full-page length together with `ilv_i`=1 runs as a linear full-page burst. For such a burst, `cfg_err_o` is high on every valid beat. `cfg_err_o` is 0 on the beats of any other burst.
- R10: A `go_i` sampled during a burst abandons that burst. The next clock shows the first beat of the new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start a burst with the settings below |
| start_col_i | input | COL_W | First column of the burst |
| len_i | input | 2 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved ordering, 0 = linear |
| wr_i | input | 1 | 1 = write burst |
| wr_single_i | input | 1 | 1 = writes transfer a single beat |
| stop_i | input | 1 | End the current burst after this beat |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | The current beat is the natural final beat |
| cfg_err_o | output | 1 | The burst uses the invalid page/interleave combination |

## Verification
Every result is due a fixed number of clock edges after its cause. The first beat appears exactly one edge after `go_i`, and beat k appears k edges later. The edge that samples `stop_i`, or the edge after the final beat, clears `beat_vld_o`. The bench drives inputs and samples outputs on falling edges. It reads beat k on the k-th falling edge after the one where `go_i` was removed. It sets `stop_i` in the same half cycle as the beat it ends, and checks that the next falling edge shows no beat.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    // Burst length selector as seen on len_i
    typedef enum logic [1:0] {
        LEN_FOUR   = 2'b00,
        LEN_EIGHT  = 2'b01,
        LEN_PAGE_A = 2'b10,
        LEN_PAGE_B = 2'b11
    } len_code_e;

    // Decoded per-burst attributes held while a burst is running
    typedef struct packed {
        logic page;    // open-ended linear burst
        logic ilv;     // interleaved ordering in effect
        logic single;  // one-beat write
        logic err;     // page length requested with interleave
    } burst_attr_t;

endpackage

// File: rtl/colgen_cfg_dec.sv
module colgen_cfg_dec
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [1:0]       len_i,
    input  logic             ilv_i,
    input  logic             wr_i,
    input  logic             wr_single_i,
    output burst_attr_t      attr_o,
    output logic [COL_W-1:0] wrap_mask_o,
    output logic [COL_W-1:0] final_idx_o
);

    localparam logic [COL_W-1:0] MASK_FOUR  = COL_W'(3);
    localparam logic [COL_W-1:0] MASK_EIGHT = COL_W'(7);
    localparam logic [COL_W-1:0] MASK_PAGE  = {COL_W{1'b1}};

    logic page_req;
    logic one_beat;

    always_comb begin
        one_beat = wr_i & wr_single_i;
        unique case (len_code_e'(len_i))
            LEN_FOUR:  begin page_req = 1'b0; wrap_mask_o = MASK_FOUR;  end
            LEN_EIGHT: begin page_req = 1'b0; wrap_mask_o = MASK_EIGHT; end
            default:   begin page_req = 1'b1; wrap_mask_o = MASK_PAGE;  end
        endcase

        attr_o.single = one_beat;
        attr_o.page   = page_req & ~one_beat;
        attr_o.ilv    = ilv_i & ~page_req;
        attr_o.err    = page_req & ilv_i & ~one_beat;

        final_idx_o   = one_beat ? '0 : wrap_mask_o;
    end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] idx_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] xor_val;

    assign lin_sum = base_i + idx_i;
    assign xor_val = base_i ^ idx_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_o[b] = mask_i[b] ? (ilv_i ? xor_val[b] : lin_sum[b]) : base_i[b];
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       len_i,
    input  logic             ilv_i,
    input  logic             wr_i,
    input  logic             wr_single_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             beat_last_o,
    output logic             cfg_err_o
);

    typedef struct packed {
        logic             vld;
        burst_attr_t      attr;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] fin;
        logic [COL_W-1:0] idx;
    } seq_state_t;

    seq_state_t  st_q, st_d;
    burst_attr_t dec_attr;
    logic [COL_W-1:0] dec_mask;
    logic [COL_W-1:0] dec_fin;
    logic        at_final;

    colgen_cfg_dec #(.COL_W(COL_W)) u_dec (
        .len_i       (len_i),
        .ilv_i       (ilv_i),
        .wr_i        (wr_i),
        .wr_single_i (wr_single_i),
        .attr_o      (dec_attr),
        .wrap_mask_o (dec_mask),
        .final_idx_o (dec_fin)
    );

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .base_i (st_q.base),
        .mask_i (st_q.mask),
        .idx_i  (st_q.idx),
        .ilv_i  (st_q.attr.ilv),
        .col_o  (col_o)
    );

    assign at_final = st_q.vld & ~st_q.attr.page & (st_q.idx == st_q.fin);

    always_comb begin
        st_d = st_q;
        if (go_i) begin
            st_d.vld  = 1'b1;
            st_d.attr = dec_attr;
            st_d.base = start_col_i;
            st_d.mask = dec_mask;
            st_d.fin  = dec_fin;
            st_d.idx  = '0;
        end else if (st_q.vld) begin
            if (stop_i || at_final) begin
                st_d.vld = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_vld_o  = st_q.vld;
    assign beat_last_o = at_final;
    assign cfg_err_o   = st_q.vld & st_q.attr.err;

endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             beat_last_o,
    input logic             cfg_err_o
);

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> (beat_vld_o && col_o == $past(start_col_i))); // R2

    AST_LAST_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last_o |-> beat_vld_o); // R5

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last_o && !go_i) |=> !beat_vld_o); // R5

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && stop_i && !go_i) |=> !beat_vld_o); // R7

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !beat_last_o); // R6

    AST_ERR_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err_o && !stop_i && !go_i) |=> (beat_vld_o && cfg_err_o && col_o == $past(col_o) + 1'b1)); // R9

    AST_ERR_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> beat_vld_o); // R9

endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go_i),
    .start_col_i (start_col_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .beat_last_o (beat_last_o),
    .cfg_err_o   (cfg_err_o)
);

// File: tb/sdram_burst_colgen_bench.sv
module sdram_burst_colgen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [1:0] len_i = '0;
    logic       ilv_i = 1'b0;
    logic       wr_i = 1'b0;
    logic       wr_single_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       beat_last_o;
    logic       cfg_err_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    sdram_burst_colgen #(.COL_W(8)) u_sdram_burst_colgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go_i),
        .start_col_i (start_col_i),
        .len_i       (len_i),
        .ilv_i       (ilv_i),
        .wr_i        (wr_i),
        .wr_single_i (wr_single_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .beat_vld_o  (beat_vld_o),
        .beat_last_o (beat_last_o),
        .cfg_err_o   (cfg_err_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int beat_col(input int s, input int len, input bit ilv, input int k);
        int mask = len - 1;
        int low  = ilv ? ((s ^ k) & mask) : ((s + k) & mask);
        return (s & ~mask & 255) | low;
    endfunction

    // stop_at < 0 means no stop request
    task automatic run_burst(input int s, input int code, input bit ilv, input bit wr,
                             input bit wrs, input int stop_at);
        bit single = wr && wrs;
        bit page   = (code >= 2) && !single;
        bit err    = (code >= 2) && ilv && !single;
        bit e_ilv  = ilv && (code < 2);
        int nat    = single ? 1 : (code == 0 ? 4 : (code == 1 ? 8 : 256));
        int nb;
        string tag;
        if (page) nb = stop_at + 1;
        else if (stop_at >= 0 && stop_at < nat) nb = stop_at + 1;
        else nb = nat;
        tag = single ? "R8" : (page ? (err ? "R9" : "R6") : (e_ilv ? "R4" : "R3"));

        @(negedge clk);
        go_i = 1'b1; start_col_i = s[7:0]; len_i = code[1:0];
        ilv_i = ilv; wr_i = wr; wr_single_i = wrs;
        @(negedge clk);
        go_i = 1'b0;
        ilv_i = ~ilv; len_i = ~len_i; start_col_i = ~start_col_i; // settings must be latched
        for (int j = 0; j < nb; j++) begin
            check(j == 0 ? "R2" : tag, beat_vld_o, 1);
            check(j == 0 ? "R2" : tag, col_o, beat_col(s, page ? 256 : nat, e_ilv, j));
            check(page ? "R6" : (single ? "R8" : "R5"), beat_last_o, (!page && j == nat - 1) ? 1 : 0);
            check("R9", cfg_err_o, err ? 1 : 0);
            if (j == stop_at) stop_i = 1'b1;
            @(negedge clk);
            stop_i = 1'b0;
        end
        check(stop_at >= 0 && stop_at < nb ? "R7" : "R5", beat_vld_o, 0);
        check("R5", beat_last_o, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c01));
        repeat (3) @(negedge clk);
        check("R1", beat_vld_o, 0);
        check("R1", beat_last_o, 0);
        check("R1", cfg_err_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", beat_vld_o, 0);
        check("R1", cfg_err_o, 0);

        // directed corner cases
        run_burst(8'hFE, 0, 0, 0, 0, -1);   // R3 wrap inside aligned four
        run_burst(8'h35, 1, 0, 0, 0, -1);   // R3 eight-beat wrap
        run_burst(8'h35, 1, 1, 0, 0, -1);   // R4 interleaved eight
        run_burst(8'h82, 0, 1, 1, 0, -1);   // R4 write, full length
        run_burst(8'hF0, 2, 0, 0, 0, 300);  // R6 wraps past 256 beats
        run_burst(8'h10, 3, 1, 0, 0, 10);   // R9 interleave with page
        run_burst(8'h44, 1, 0, 1, 1, -1);   // R8 single write
        run_burst(8'h44, 1, 0, 0, 1, -1);   // R8 read keeps length
        run_burst(8'h20, 2, 0, 1, 1, -1);   // R8 single write overrides page
        run_burst(8'h60, 1, 0, 0, 0, 1);    // R7 stop early

        // R10 restart during a burst
        @(negedge clk);
        go_i = 1'b1; start_col_i = 8'h10; len_i = 2'b01; ilv_i = 1'b0; wr_i = 1'b0; wr_single_i = 1'b0;
        @(negedge clk);
        go_i = 1'b0;
        check("R10", col_o, 8'h10);
        @(negedge clk);
        check("R10", col_o, 8'h11);
        go_i = 1'b1; start_col_i = 8'h45; len_i = 2'b00;
        @(negedge clk);
        go_i = 1'b0;
        for (int j = 0; j < 4; j++) begin
            check("R10", beat_vld_o, 1);
            check("R10", col_o, beat_col(8'h45, 4, 0, j));
            check("R10", beat_last_o, j == 3 ? 1 : 0);
            @(negedge clk);
        end
        check("R10", beat_vld_o, 0);

        // constrained random bursts
        for (int n = 0; n < 80; n++) begin
            int code = int'($urandom % 4);
            int stp;
            if (code >= 2) stp = 3 + int'($urandom % 40);
            else stp = ($urandom % 2) ? -1 : int'($urandom % 8);
            run_burst(int'($urandom % 256), code, 1'($urandom), 1'($urandom), 1'($urandom), stp);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule